// File: doc/BRIEF.md
# Latched Byte-Bus Host Initiator

This block sits between a processor-side request port and an 8-bit expansion bus whose targets hold their address and data in small addressable latches. For each request it selects one latch at a time and loads it with one byte, then issues a single-cycle read or write strobe. After the strobe it holds the requester off until the target raises its completion line, and then it hands back the read byte or a write acknowledge.

To shorten runs of consecutive byte accesses, the host remembers the last address it sent. When a new address repeats the upper three bytes and raises the low byte by one without a carry, only the low address latch is reloaded. A write also reloads the data latch. A build parameter switches the shortcut off, so that every access reloads all four address latches. If the target never answers, a watchdog counter ends the transaction with an error. The watchdog also clears the remembered address, so that the next access starts from a full load.

Top module: `lbb_host`

## Requirements
- R1: After reset, req_ready is 1 and bus_load, bus_wr_stb, bus_rd_stb and rsp_valid are 0. The address memory is empty, so the first access performs a full load.
- R2: A full write loads latches 0, 1, 2 and 3 in that order, each with the address byte whose bits sit at 8*k+7..8*k for latch k. It then loads latch 7 with req_wdata and asserts bus_wr_stb for one cycle.
- R3: A full read loads latches 0 to 3 in that order and then asserts bus_rd_stb for one cycle. It does not load latch 7.
- R4: A write whose address keeps bits 31..8 of the previous access and whose bits 7..0 equal the previous low byte plus one loads only latch 0 and then latch 7 before its strobe.
- R5: A read that meets the same address condition loads only latch 0 before its strobe.
- R6: req_ready stays 0 from the accepting edge until the transaction ends. One cycle after the edge that samples bus_done high, rsp_valid pulses for one cycle with rsp_err 0. For a read, rsp_rdata then equals the bus_din sampled with bus_done.
- R7: A full load is performed when the low byte of the previous address is 0xFF (carry case), when the address is unchanged, or when the upper 24 bits differ.
- R8: If bus_done is not seen within TIMEOUT cycles after the strobe, rsp_valid pulses with rsp_err 1 and the host returns to idle.
- R9: After a timeout the next access performs a full load, even if its address is the previous one plus one.
- R10: With SHORTCUT_EN = 0, every read loads four address latches and every write loads five latches.
- R11: Each latch load lasts one cycle with bus_load high. A strobe never coincides with a load or with the other strobe. Exactly one strobe cycle is issued per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted on a clock edge when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Host idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a timeout |
| rsp_rdata | output | 8 | Byte returned by a read |
| bus_sel | output | 3 | Latch index being loaded |
| bus_dout | output | 8 | Byte driven to the selected latch |
| bus_load | output | 1 | Latch load enable |
| bus_wr_stb | output | 1 | Write transaction strobe |
| bus_rd_stb | output | 1 | Read transaction strobe |
| bus_done | input | 1 | Transaction complete from the target |
| bus_din | input | 8 | Read byte from the target |

## Verification
The bench builds two copies of the host. Both use TIMEOUT = 16, so an unanswered transaction aborts within a few dozen cycles and the timeout and the address-forgetting path can be reached quickly. One copy keeps SHORTCUT_EN = 1, which exercises the burst rule in its hit, carry, repeat and distant-address forms. The other copy uses SHORTCUT_EN = 0 and shows that sequential addresses still load every address latch.

// File: rtl/lbb_pkg.sv
package lbb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_STRB,
    ST_WAIT
  } lbb_state_e;
endpackage

// File: rtl/lbb_rst_sync.sv
module lbb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lbb_addr_cache.sv
// Remembers the last address sent and flags a carry-free +1 successor.
module lbb_addr_cache #(
  parameter int ADDR_W      = 32,
  parameter int LOW_W       = 8,
  parameter bit SHORTCUT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              inval,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit
);
  localparam logic [LOW_W-1:0] LOW_ONE = LOW_W'(1);
  localparam logic [LOW_W-1:0] LOW_TOP = '1;

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] last_q, last_d;

  always_comb begin
    valid_d = valid_q;
    last_d  = last_q;
    if (inval) begin
      valid_d = 1'b0;
    end else if (upd) begin
      valid_d = 1'b1;
      last_d  = upd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (upd) last_q <= last_d;
    end
  end

  generate
    if (SHORTCUT_EN) begin : g_short
      assign hit = valid_q
                && (probe_addr[ADDR_W-1:LOW_W] == last_q[ADDR_W-1:LOW_W])
                && (last_q[LOW_W-1:0] != LOW_TOP)
                && (probe_addr[LOW_W-1:0] == last_q[LOW_W-1:0] + LOW_ONE);
    end else begin : g_full
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lbb_timer.sv
module lbb_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || en) cnt_q <= cnt_d;
  end

  assign expired = en && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/lbb_seq.sv
// Transaction sequencer: latch loads, strobe, completion wait.
module lbb_seq
  import lbb_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int ADDR_BYTES = 4,
  parameter int SEL_W      = 3,
  parameter int DATA_LATCH = 7,
  localparam int ADDR_W    = BUS_W * ADDR_BYTES,
  localparam int IDX_W     = $clog2(ADDR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic              short_hit,
  output logic              cache_upd,
  output logic              cache_inval,
  output logic              tmr_clr,
  output logic              tmr_en,
  input  logic              tmr_expired,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_load,
  output logic              bus_wr_stb,
  output logic              bus_rd_stb,
  input  logic              bus_done,
  input  logic [BUS_W-1:0]  bus_din
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

  lbb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, end_q, end_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_W-1:0]  wdata_q, wdata_d, rdata_q, rdata_d;
  logic              wr_q, wr_d, rspv_q, rspv_d, err_q, err_d;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    end_d       = end_q;
    addr_d      = addr_q;
    wdata_d     = wdata_q;
    wr_d        = wr_q;
    rdata_d     = rdata_q;
    rspv_d      = 1'b0;
    err_d       = 1'b0;
    cache_upd   = 1'b0;
    cache_inval = 1'b0;
    tmr_clr     = 1'b0;
    tmr_en      = 1'b0;
    bus_load    = 1'b0;
    bus_sel     = '0;
    bus_dout    = '0;
    bus_wr_stb  = 1'b0;
    bus_rd_stb  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d    = req_addr;
          wdata_d   = req_wdata;
          wr_d      = req_write;
          idx_d     = '0;
          end_d     = short_hit ? '0 : IDX_LAST;
          cache_upd = 1'b1;
          state_d   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        bus_load = 1'b1;
        bus_sel  = {{(SEL_W-IDX_W){1'b0}}, idx_q};
        bus_dout = addr_q[idx_q*BUS_W +: BUS_W];
        if (idx_q == end_q) state_d = wr_q ? ST_DATA : ST_STRB;
        else                idx_d   = idx_q + 1'b1;
      end
      ST_DATA: begin
        bus_load = 1'b1;
        bus_sel  = SEL_W'(DATA_LATCH);
        bus_dout = wdata_q;
        state_d  = ST_STRB;
      end
      ST_STRB: begin
        bus_wr_stb = wr_q;
        bus_rd_stb = !wr_q;
        tmr_clr    = 1'b1;
        state_d    = ST_WAIT;
      end
      ST_WAIT: begin
        tmr_en = 1'b1;
        if (bus_done) begin
          rspv_d  = 1'b1;
          rdata_d = bus_din;
          state_d = ST_IDLE;
        end else if (tmr_expired) begin
          rspv_d      = 1'b1;
          err_d       = 1'b1;
          cache_inval = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      end_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
      rspv_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rspv_q  <= rspv_d;
      err_q   <= err_d;
      if (cache_upd) begin
        end_q   <= end_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        wr_q    <= wr_d;
      end
      if (rspv_d) rdata_q <= rdata_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rspv_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/lbb_host.sv
module lbb_host #(
  parameter int BUS_W       = 8,
  parameter int ADDR_BYTES  = 4,
  parameter int SEL_W       = 3,
  parameter int DATA_LATCH  = 7,
  parameter int TIMEOUT     = 1024,
  parameter bit SHORTCUT_EN = 1'b1,
  localparam int ADDR_W     = BUS_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_load,
  output logic              bus_wr_stb,
  output logic              bus_rd_stb,
  input  logic              bus_done,
  input  logic [BUS_W-1:0]  bus_din
);
  logic rst_sync_n;
  logic short_hit, cache_upd, cache_inval;
  logic tmr_clr, tmr_en, tmr_expired;

  lbb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbb_addr_cache #(
    .ADDR_W      (ADDR_W),
    .LOW_W       (BUS_W),
    .SHORTCUT_EN (SHORTCUT_EN)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd        (cache_upd),
    .upd_addr   (req_addr),
    .inval      (cache_inval),
    .probe_addr (req_addr),
    .hit        (short_hit)
  );

  lbb_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .expired (tmr_expired)
  );

  lbb_seq #(
    .BUS_W      (BUS_W),
    .ADDR_BYTES (ADDR_BYTES),
    .SEL_W      (SEL_W),
    .DATA_LATCH (DATA_LATCH)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .short_hit   (short_hit),
    .cache_upd   (cache_upd),
    .cache_inval (cache_inval),
    .tmr_clr     (tmr_clr),
    .tmr_en      (tmr_en),
    .tmr_expired (tmr_expired),
    .bus_sel     (bus_sel),
    .bus_dout    (bus_dout),
    .bus_load    (bus_load),
    .bus_wr_stb  (bus_wr_stb),
    .bus_rd_stb  (bus_rd_stb),
    .bus_done    (bus_done),
    .bus_din     (bus_din)
  );
endmodule

// File: rtl/lbb_host_chk.sv
module lbb_host_chk #(
  parameter int ADDR_BYTES  = 4,
  parameter int SEL_W       = 3,
  parameter int DATA_LATCH  = 7,
  parameter bit SHORTCUT_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [SEL_W-1:0] bus_sel,
  input logic             bus_load,
  input logic             bus_wr_stb,
  input logic             bus_rd_stb
);
  logic any_stb;
  assign any_stb = bus_wr_stb || bus_rd_stb;

  assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> !any_stb);

  assert_stb_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_load && any_stb) && !(bus_wr_stb && bus_rd_stb));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_load || any_stb) |-> !req_ready);

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_err_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  assert_wr_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_stb |-> $past(bus_load && (bus_sel == SEL_W'(DATA_LATCH))));

  generate
    if (!SHORTCUT_EN) begin : g_full_chk
      assert_rd_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_stb |-> ($past(bus_load) && ($past(bus_sel) == SEL_W'(ADDR_BYTES - 1))));
    end
  endgenerate
endmodule

bind lbb_host lbb_host_chk #(
  .ADDR_BYTES  (ADDR_BYTES),
  .SEL_W       (SEL_W),
  .DATA_LATCH  (DATA_LATCH),
  .SHORTCUT_EN (SHORTCUT_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .bus_sel    (bus_sel),
  .bus_load   (bus_load),
  .bus_wr_stb (bus_wr_stb),
  .bus_rd_stb (bus_rd_stb)
);

// File: tb/test_lbb_host.sv
`timescale 1ns/1ps
module test_lbb_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        bus_done = 1'b0;
  logic [7:0]  bus_din = '0;
  logic        use_b = 1'b0;

  logic a_ready, a_rspv, a_err, a_load, a_wr, a_rd;
  logic [7:0] a_rdata, a_dout;
  logic [2:0] a_sel;
  logic b_ready, b_rspv, b_err, b_load, b_wr, b_rd;
  logic [7:0] b_rdata, b_dout;
  logic [2:0] b_sel;

  always #5 clk = ~clk;

  lbb_host #(.TIMEOUT(16), .SHORTCUT_EN(1'b1)) i_lbb_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !use_b), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(a_ready), .rsp_valid(a_rspv),
    .rsp_err(a_err), .rsp_rdata(a_rdata), .bus_sel(a_sel), .bus_dout(a_dout),
    .bus_load(a_load), .bus_wr_stb(a_wr), .bus_rd_stb(a_rd), .bus_done(bus_done),
    .bus_din(bus_din));

  lbb_host #(.TIMEOUT(16), .SHORTCUT_EN(1'b0)) i_lbb_host_full (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && use_b), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(b_ready), .rsp_valid(b_rspv),
    .rsp_err(b_err), .rsp_rdata(b_rdata), .bus_sel(b_sel), .bus_dout(b_dout),
    .bus_load(b_load), .bus_wr_stb(b_wr), .bus_rd_stb(b_rd), .bus_done(bus_done),
    .bus_din(bus_din));

  logic m_ready, m_rspv, m_err, m_load, m_wr, m_rd;
  logic [7:0] m_rdata, m_dout;
  logic [2:0] m_sel;
  assign m_ready = use_b ? b_ready : a_ready;
  assign m_rspv  = use_b ? b_rspv  : a_rspv;
  assign m_err   = use_b ? b_err   : a_err;
  assign m_rdata = use_b ? b_rdata : a_rdata;
  assign m_load  = use_b ? b_load  : a_load;
  assign m_wr    = use_b ? b_wr    : a_wr;
  assign m_rd    = use_b ? b_rd    : a_rd;
  assign m_sel   = use_b ? b_sel   : a_sel;
  assign m_dout  = use_b ? b_dout  : a_dout;

  // Target-side monitor: latch model and event counters.
  logic [7:0] lat [0:7];
  logic [2:0] seq_log [0:63];
  int n_load = 0, n_wr = 0, n_rd = 0, n_bad = 0;
  logic prev_stb = 1'b0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (m_load) begin
        lat[m_sel] <= m_dout;
        seq_log[n_load % 64] <= m_sel;
        n_load <= n_load + 1;
      end
      if (m_wr) n_wr <= n_wr + 1;
      if (m_rd) n_rd <= n_rd + 1;
      if ((m_wr || m_rd) && (m_load || prev_stb || (m_wr && m_rd))) n_bad <= n_bad + 1;
      prev_stb <= m_wr || m_rd;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // One transaction; respond=0 leaves the target silent.
  task automatic xfer(input string req, input bit wr, input logic [31:0] a,
                      input logic [7:0] wd, input logic [7:0] rtgt, input int dly,
                      input bit respond, input int exp_loads);
    int l0, w0, r0, cyc;
    bit full;
    @(negedge clk);
    check(req, "ready before request", int'(m_ready), 1);
    l0 = n_load; w0 = n_wr; r0 = n_rd;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (n_wr == w0 && n_rd == r0 && cyc < 50) begin
      @(negedge clk); cyc++;
    end
    check(req, "stalled after strobe", int'(m_ready), 0);
    if (respond) begin
      repeat (dly) @(negedge clk);
      check(req, "stalled while waiting", int'(m_ready), 0);
      bus_din = rtgt; bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
    end
    cyc = 0;
    while (!m_rspv && cyc < 100) begin
      @(negedge clk); cyc++;
    end
    check(req, "rsp_valid", int'(m_rspv), 1);
    check(req, "rsp_err", int'(m_err), respond ? 0 : 1);
    if (respond && !wr) check(req, "rsp_rdata", int'(m_rdata), int'(rtgt));
    check(req, "load count", n_load - l0, exp_loads);
    check(req, "write strobes", n_wr - w0, wr ? 1 : 0);
    check(req, "read strobes", n_rd - r0, wr ? 0 : 1);
    full = (exp_loads >= 4);
    if (full) begin
      for (int k = 0; k < 4; k++) begin
        check(req, "latch order", int'(seq_log[(l0 + k) % 64]), k);
        check(req, "address latch", int'(lat[k]), int'(a[8*k +: 8]));
      end
    end else begin
      check(req, "low latch first", int'(seq_log[l0 % 64]), 0);
      check(req, "low address latch", int'(lat[0]), int'(a[7:0]));
    end
    if (wr) begin
      check(req, "data latch index", int'(seq_log[(l0 + exp_loads - 1) % 64]), 7);
      check(req, "data latch", int'(lat[7]), int'(wd));
    end
    @(negedge clk);
    check(req, "rsp one cycle", int'(m_rspv), 0);
    check(req, "ready after rsp", int'(m_ready), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "load in reset", int'(a_load), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "req_ready", int'(a_ready), 1);
    check("R1", "rsp_valid", int'(a_rspv), 0);
    check("R1", "strobes", int'(a_wr || a_rd || a_load), 0);
    check("R1", "full-only req_ready", int'(b_ready), 1);
  endtask

  task automatic t_full_write();
    xfer("R1_R2 first write full", 1'b1, 32'h1234_5678, 8'hA5, 8'h00, 1, 1'b1, 5);
  endtask

  task automatic t_burst();
    xfer("R4 burst write", 1'b1, 32'h1234_5679, 8'h3C, 8'h00, 0, 1'b1, 2);
    xfer("R5_R6 burst read", 1'b0, 32'h1234_567A, 8'h00, 8'h9E, 2, 1'b1, 1);
    xfer("R5 burst read again", 1'b0, 32'h1234_567B, 8'h00, 8'h41, 4, 1'b1, 1);
  endtask

  task automatic t_full_cases();
    xfer("R3_R7 distant read", 1'b0, 32'h0000_00FF, 8'h00, 8'h77, 0, 1'b1, 4);
    xfer("R7 carry read", 1'b0, 32'h0000_0100, 8'h00, 8'h12, 1, 1'b1, 4);
    xfer("R7 same address", 1'b0, 32'h0000_0100, 8'h00, 8'h34, 1, 1'b1, 4);
    xfer("R7 upper differs", 1'b1, 32'h0001_0101, 8'h5A, 8'h00, 0, 1'b1, 5);
  endtask

  task automatic t_timeout();
    xfer("R5 burst before timeout", 1'b0, 32'h0001_0102, 8'h00, 8'h66, 0, 1'b1, 1);
    xfer("R8 timeout", 1'b0, 32'h0001_0103, 8'h00, 8'h00, 0, 1'b0, 1);
    xfer("R9 full after timeout", 1'b0, 32'h0001_0104, 8'h00, 8'hC3, 0, 1'b1, 4);
    xfer("R9 burst resumes", 1'b1, 32'h0001_0105, 8'hE1, 8'h00, 0, 1'b1, 2);
  endtask

  task automatic t_full_only();
    @(negedge clk);
    use_b = 1'b1;
    xfer("R10 first read", 1'b0, 32'h0000_0200, 8'h00, 8'h81, 0, 1'b1, 4);
    xfer("R10 sequential read", 1'b0, 32'h0000_0201, 8'h00, 8'h82, 1, 1'b1, 4);
    xfer("R10 sequential write", 1'b1, 32'h0000_0202, 8'hBB, 8'h00, 0, 1'b1, 5);
    @(negedge clk);
    use_b = 1'b0;
  endtask

  task automatic t_strobe_shape();
    @(negedge clk);
    check("R11", "strobe overlap or width violations", n_bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_full_write();
    t_burst();
    t_full_cases();
    t_timeout();
    t_full_only();
    t_strobe_shape();
    summary();
    $finish;
  end
endmodule